// File: doc/BRIEF.md
# Linear Frequency Sweep Sequencer

This block generates the tuning word for a stepped linear frequency sweep. A start strobe captures a start word, a step magnitude with a direction bit, an increment count, a dwell length and a dwell mode. The block then presents the start word on its output. After each dwell it moves the word by one step, and it does this until the programmed number of increments has been taken. The end frequency is never programmed. It follows from the start word plus the increment count times the step.

The dwell on each frequency is counted in one of two units, chosen by the mode bit. The first unit is master clock periods. The second is completed periods of the output waveform, which arrive as single-clock pulses from the phase accumulator that follows this block. When the last frequency's dwell is complete, the block holds the final word, drops busy and raises done for one clock. The phase accumulator, the amplitude lookup and the converter sit outside this block.

Top module: `freq_sweep_seq`

## Requirements
- R1: After reset, freqWord is 0 and busy and done are 0. On a clock edge with startPulse high, all configuration inputs are captured, freqWord takes startWord and busy is 1 after that same edge.
- R2: Each advance adds the captured stepMag to freqWord when stepDown is 0 and subtracts it when stepDown is 1. The result wraps modulo 2^24.
- R3: A sweep outputs incrCount+1 frequencies. The k-th frequency (k = 0 at the start) is startWord plus or minus k times stepMag. The last one is startWord plus or minus incrCount times stepMag.
- R4: With dwellByCycles = 0, each frequency is present on freqWord for exactly dwellCount clock periods, counted from the start edge.
- R5: With dwellByCycles = 1, each frequency is held until dwellCount cycleTick pulses have been sampled while busy. A cycleTick pulse on the start edge is not counted. Clock cycles without a pulse do not advance the sweep.
- R6: On the edge that ends the last frequency's dwell, busy falls and done rises. done stays high for exactly one clock, and freqWord keeps the final frequency.
- R7: A startPulse while busy restarts the sweep. freqWord returns to the new startWord and dwell timing restarts from that edge.
- R8: While idle, freqWord is unchanged, and cycleTick has no effect on freqWord, busy or done.
- R9: A dwellCount or incrCount below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| startWord | input | 24 | First tuning word of the sweep |
| stepMag | input | 23 | Step magnitude |
| stepDown | input | 1 | 1 = falling sweep, 0 = rising sweep |
| incrCount | input | 12 | Number of increments (2 to 4095) |
| dwellCount | input | 11 | Dwell per frequency in units (2 to 2047) |
| dwellByCycles | input | 1 | 1 = dwell unit is one output cycle, 0 = one clock |
| startPulse | input | 1 | Captures configuration and starts or restarts the sweep |
| cycleTick | input | 1 | Single-clock pulse marking one completed output cycle |
| freqWord | output | 24 | Current tuning word |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-clock pulse when the sweep completes |

## Verification
A wrong dwell counter shows up as a change of freqWord one or more clocks early or late. It is visible at the first step of the sweep, so it appears within one dwell of the start edge. A wrong increment index moves the fall of busy and the done pulse, and it leaves a final word that differs from start plus count times step. The bench compares freqWord, busy and done against arithmetic expectations on every clock of each sweep. This catches a timing slip on the cycle where it happens rather than only at the end of the sweep.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int unsigned MIN_SETTING = 2;

  typedef struct packed {
    logic load;
    logic step;
  } sweep_ctrl_t;
endpackage

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int STEP_W = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweep_ctrl_t       ctrl,
  input  logic [WORD_W-1:0] startWord,
  input  logic [STEP_W-1:0] stepMag,
  input  logic              stepDown,
  output logic [WORD_W-1:0] freqWord
);
  logic [STEP_W-1:0] magReg;
  logic              downReg;
  logic [WORD_W-1:0] stepExt;

  assign stepExt = WORD_W'(magReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqWord <= '0;
      magReg   <= '0;
      downReg  <= 1'b0;
    end else if (ctrl.load) begin
      freqWord <= startWord;
      magReg   <= stepMag;
      downReg  <= stepDown;
    end else if (ctrl.step) begin
      freqWord <= downReg ? (freqWord - stepExt) : (freqWord + stepExt);
    end
  end

  // R8: with neither strobe, the word must not move
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step) |=> $stable(freqWord));
endmodule

// File: rtl/sweep_control.sv
module sweep_control
  import sweep_pkg::*;
#(
  parameter int COUNT_W = 12,
  parameter int DWELL_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COUNT_W-1:0] incrCount,
  input  logic [DWELL_W-1:0] dwellCount,
  input  logic               dwellByCycles,
  input  logic               startPulse,
  input  logic               cycleTick,
  output sweep_ctrl_t        ctrl,
  output logic               busy,
  output logic               done
);
  localparam logic [COUNT_W-1:0] COUNT_MIN = COUNT_W'(MIN_SETTING);
  localparam logic [DWELL_W-1:0] DWELL_MIN = DWELL_W'(MIN_SETTING);

  logic [DWELL_W-1:0] dwellCnt;
  logic [DWELL_W-1:0] dwellLast;
  logic [COUNT_W-1:0] stepIdx;
  logic [COUNT_W-1:0] countLim;
  logic               modeCycles;
  logic               unitTick;
  logic               dwellEnd;
  logic               lastFreq;

  assign unitTick = modeCycles ? cycleTick : 1'b1;
  assign dwellEnd = busy && unitTick && (dwellCnt == dwellLast);
  assign lastFreq = (stepIdx == countLim);

  always_comb begin
    ctrl      = '0;
    ctrl.load = startPulse;
    ctrl.step = !startPulse && dwellEnd && !lastFreq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      dwellCnt   <= '0;
      dwellLast  <= DWELL_MIN - DWELL_W'(1);
      stepIdx    <= '0;
      countLim   <= COUNT_MIN;
      modeCycles <= 1'b0;
    end else if (startPulse) begin
      busy       <= 1'b1;
      done       <= 1'b0;
      dwellCnt   <= '0;
      stepIdx    <= '0;
      modeCycles <= dwellByCycles;
      dwellLast  <= ((dwellCount < DWELL_MIN) ? DWELL_MIN : dwellCount) - DWELL_W'(1);
      countLim   <= (incrCount < COUNT_MIN) ? COUNT_MIN : incrCount;
    end else begin
      done <= 1'b0;
      if (busy && unitTick) begin
        if (dwellEnd) begin
          dwellCnt <= '0;
          if (lastFreq) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            stepIdx <= stepIdx + COUNT_W'(1);
          end
        end else begin
          dwellCnt <= dwellCnt + DWELL_W'(1);
        end
      end
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_idle_no_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ctrl.step);

  assert_dwell_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (dwellCnt <= dwellLast));

  assert_index_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepIdx <= countLim));

  assert_cycle_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeCycles && !cycleTick && !startPulse) |=>
      ($stable(dwellCnt) && $stable(stepIdx) && busy));
endmodule

// File: rtl/freq_sweep_seq.sv
module freq_sweep_seq
  import sweep_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int STEP_W  = 23,
  parameter int COUNT_W = 12,
  parameter int DWELL_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  startWord,
  input  logic [STEP_W-1:0]  stepMag,
  input  logic               stepDown,
  input  logic [COUNT_W-1:0] incrCount,
  input  logic [DWELL_W-1:0] dwellCount,
  input  logic               dwellByCycles,
  input  logic               startPulse,
  input  logic               cycleTick,
  output logic [WORD_W-1:0]  freqWord,
  output logic               busy,
  output logic               done
);
  sweep_ctrl_t ctrl;

  sweep_control #(.COUNT_W(COUNT_W), .DWELL_W(DWELL_W)) u_control (
    .clk(clk), .rstN(rstN), .incrCount(incrCount), .dwellCount(dwellCount),
    .dwellByCycles(dwellByCycles), .startPulse(startPulse),
    .cycleTick(cycleTick), .ctrl(ctrl), .busy(busy), .done(done)
  );

  sweep_datapath #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startWord(startWord),
    .stepMag(stepMag), .stepDown(stepDown), .freqWord(freqWord)
  );
endmodule

// File: tb/freq_sweep_seq_bench.sv
module freq_sweep_seq_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] startWord = '0;
  logic [22:0] stepMag = '0;
  logic        stepDown = 1'b0;
  logic [11:0] incrCount = '0;
  logic [10:0] dwellCount = '0;
  logic        dwellByCycles = 1'b0;
  logic        startPulse = 1'b0;
  logic        cycleTick = 1'b0;
  logic [23:0] freqWord;
  logic        busy;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_sweep_seq u_freq_sweep_seq (
    .clk(clk), .rstN(rstN), .startWord(startWord), .stepMag(stepMag),
    .stepDown(stepDown), .incrCount(incrCount), .dwellCount(dwellCount),
    .dwellByCycles(dwellByCycles), .startPulse(startPulse),
    .cycleTick(cycleTick), .freqWord(freqWord), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] expF(input logic [23:0] s, input logic [22:0] m,
                                       input logic dn, input int k);
    logic [47:0] prod;
    prod = 48'(k) * 48'(m);
    return dn ? (s - prod[23:0]) : (s + prod[23:0]);
  endfunction

  task automatic startSweep(input logic [23:0] s, input logic [22:0] m, input logic dn,
                            input logic [11:0] n, input logic [10:0] d,
                            input logic cyc, input logic tickAtStart);
    startWord = s; stepMag = m; stepDown = dn; incrCount = n;
    dwellCount = d; dwellByCycles = cyc; startPulse = 1'b1; cycleTick = tickAtStart;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0; cycleTick = 1'b0;
    startWord = ~s; stepMag = ~m; stepDown = ~dn; incrCount = '0; dwellCount = '0;
  endtask

  // Clock-mode check: sample at t clocks after the start edge
  task automatic checkClock(input logic [23:0] s, input logic [22:0] m, input logic dn,
                            input int n, input int d, input int limit);
    int total;
    total = (n + 1) * d;
    for (int t = 0; t <= total + 1 && t < limit; t++) begin
      if (t < total) begin
        chk(freqWord == expF(s, m, dn, t / d), "R4 R3 R2 freq", freqWord, expF(s, m, dn, t / d));
        chk(busy && !done, "R4 busy during sweep", {busy, done}, 2'b10);
      end else if (t == total) begin
        chk(freqWord == expF(s, m, dn, n), "R3 final freq", freqWord, expF(s, m, dn, n));
        chk(!busy && done, "R6 done pulse", {busy, done}, 2'b01);
      end else begin
        chk(freqWord == expF(s, m, dn, n), "R6 final hold", freqWord, expF(s, m, dn, n));
        chk(!busy && !done, "R6 done one clock", {busy, done}, 2'b00);
      end
      @(negedge clk);
    end
  endtask

  task automatic runCycle(input logic [23:0] s, input logic [22:0] m, input logic dn,
                          input int n, input int d);
    startSweep(s, m, dn, 12'(n), 11'(d), 1'b1, 1'b1);
    for (int i = 0; i <= n; i++) begin
      for (int j = 0; j < d; j++) begin
        repeat (3) begin
          chk(freqWord == expF(s, m, dn, i), "R5 hold without tick", freqWord, expF(s, m, dn, i));
          chk(busy && !done, "R5 busy without tick", {busy, done}, 2'b10);
          @(negedge clk);
        end
        cycleTick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cycleTick = 1'b0;
        if (j < d - 1) begin
          chk(freqWord == expF(s, m, dn, i), "R5 partial dwell", freqWord, expF(s, m, dn, i));
        end else if (i < n) begin
          chk(freqWord == expF(s, m, dn, i + 1), "R5 step on tick", freqWord, expF(s, m, dn, i + 1));
          chk(busy, "R5 still busy", busy, 1);
        end else begin
          chk(freqWord == expF(s, m, dn, n), "R3 R5 final", freqWord, expF(s, m, dn, n));
          chk(!busy && done, "R6 done after ticks", {busy, done}, 2'b01);
        end
      end
    end
    @(negedge clk);
    chk(!done, "R6 done clears", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(freqWord == 24'h0, "R1 reset word", freqWord, 0);
    chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R4 R2 rising, clock mode, several shapes
    for (int d = 2; d <= 4; d++) begin
      for (int n = 2; n <= 4; n++) begin
        startSweep(24'h001000 + 24'(n), 23'h000123 * 23'(d), 1'b0, 12'(n), 11'(d), 1'b0, 1'b0);
        chk(freqWord == 24'h001000 + 24'(n), "R1 start word", freqWord, 24'h001000 + 24'(n));
        checkClock(24'h001000 + 24'(n), 23'h000123 * 23'(d), 1'b0, n, d, 1 << 30);
      end
    end
    // R2 falling and wrap both ways
    startSweep(24'h000010, 23'h000030, 1'b1, 12'd3, 11'd2, 1'b0, 1'b0);
    checkClock(24'h000010, 23'h000030, 1'b1, 3, 2, 1 << 30);
    startSweep(24'hFFFFF0, 23'h7FFFFF, 1'b0, 12'd5, 11'd3, 1'b0, 1'b0);
    checkClock(24'hFFFFF0, 23'h7FFFFF, 1'b0, 5, 3, 1 << 30);
    // R3 maximum increment count, R4 maximum dwell
    startSweep(24'h100000, 23'h000777, 1'b1, 12'd4095, 11'd2, 1'b0, 1'b0);
    checkClock(24'h100000, 23'h000777, 1'b1, 4095, 2, 1 << 30);
    startSweep(24'h200000, 23'h012345, 1'b0, 12'd2, 11'd2047, 1'b0, 1'b0);
    checkClock(24'h200000, 23'h012345, 1'b0, 2, 2047, 1 << 30);
    // R9 settings below minimum
    startSweep(24'h300000, 23'h000100, 1'b0, 12'd1, 11'd0, 1'b0, 1'b0);
    checkClock(24'h300000, 23'h000100, 1'b0, 2, 2, 1 << 30);
    startSweep(24'h300000, 23'h000100, 1'b1, 12'd0, 11'd1, 1'b0, 1'b0);
    checkClock(24'h300000, 23'h000100, 1'b1, 2, 2, 1 << 30);

    // R5 cycle mode
    runCycle(24'h050000, 23'h001111, 1'b0, 2, 2);
    runCycle(24'h000100, 23'h000300, 1'b1, 3, 3);

    // R8 idle: ticks and waiting do not move anything
    for (int k = 0; k < 6; k++) begin
      cycleTick = k[0];
      @(negedge clk);
      chk(freqWord == expF(24'h000100, 23'h000300, 1'b1, 3), "R8 idle hold", freqWord,
          expF(24'h000100, 23'h000300, 1'b1, 3));
      chk(!busy && !done, "R8 idle flags", {busy, done}, 0);
    end
    cycleTick = 1'b0;

    // R7 restart while busy
    startSweep(24'h400000, 23'h000050, 1'b0, 12'd5, 11'd3, 1'b0, 1'b0);
    checkClock(24'h400000, 23'h000050, 1'b0, 5, 3, 7);
    startSweep(24'h500000, 23'h000020, 1'b1, 12'd2, 11'd4, 1'b0, 1'b0);
    chk(freqWord == 24'h500000, "R7 restart word", freqWord, 24'h500000);
    checkClock(24'h500000, 23'h000020, 1'b1, 2, 4, 1 << 30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule